// File: doc/BRIEF.md
# Multi-bit ring oscillator response extractor

This block derives a device-identification response from an array of ring oscillators. It powers one oscillator at a time and counts that oscillator's rising edges across a fixed window of reference-clock cycles. Oscillators are taken in disjoint neighbouring pairs: index 0 against 1, index 2 against 3, and so on. Each pair yields a 32-bit signed-magnitude word. The top bit is the sign and the lower 31 bits are the absolute difference of the two counts.

Every pair always contributes its sign bit. Software can also choose up to three positions inside the magnitude field, and each chosen position adds one more bit per pair. Bits from the same position across all pairs are gathered into one plane, and the planes are packed side by side into a single response vector. With no extra position chosen, the response is the classic one-bit-per-pair comparison result.

Top module: `ro_multibit_puf`

## Requirements
- R1: At most one bit of `osc_en` is high in any cycle. Index 2k+1 is enabled only after index 2k, and pair k only after pair k-1. Each enable lasts exactly WIN_CYCLES cycles and follows SETTLE_CYCLES cycles in which `osc_en` is all zero. `osc_en` stays zero through the two cycles between pairs.
- R2: The count for an oscillator is the number of rising edges seen on `osc_toggle` while its enable is high. The count saturates at 2^CNT_W-1 and does not wrap.
- R3: The sign bit of a pair is 1 when the count of the lower-indexed oscillator is strictly greater than the count of the higher-indexed one, and 0 otherwise. Equal counts give a sign of 0 and a magnitude of 0.
- R4: The magnitude field is the absolute count difference in 31 bits. Selected plane j (j = 0..2) takes bit `cfg_pos[5j+4:5j]` of that field for every pair. A position above 30 yields 0.
- R5: The sign plane sits in `response` bits [P-1:0], where P = N_OSC/2. Selected plane j sits in bits [(j+2)P-1:(j+1)P]. Pair k maps to bit k of its plane. A plane with j >= `cfg_n_extra` reads as 0.
- R6: `cfg_n_extra` and `cfg_pos` are sampled only when a start is accepted in idle. Changes during a run do not affect that run's response.
- R7: `done` is high for exactly one cycle, two cycles after the last pair's second window ends. `response` then holds until the next accepted start, which clears it.
- R8: While reset is asserted and after it is released, `done` is 0, `osc_en` is all zero and `response` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Pulse that begins a full measurement run when idle |
| cfg_n_extra | input | 2 | Number of magnitude planes added after the sign plane (0..3) |
| cfg_pos | input | 15 | Three 5-bit magnitude bit positions; plane j uses bits [5j+4:5j] |
| osc_en | output | N_OSC | One-hot enable for the oscillator being measured |
| osc_toggle | input | 1 | Output of the oscillator array, one oscillator active at a time |
| done | output | 1 | One-cycle pulse at the end of a run |
| response | output | 2*N_OSC | Packed response planes |

## Verification
The bench builds the block with eight oscillators, a 6-bit counter, a 160-cycle window and a 4-cycle settle gap. These values make a full run cost about 1,300 cycles. Counts above 63 then exercise saturation, and low magnitude positions such as 0 to 5 flip across the chosen pairs, so every plane shows both values. A cycle-by-cycle model tracks the enable schedule and the done pulse. Runs cover equal counts, zero counts, saturated counts, all plane widths, and a configuration change in the middle of a run.

// File: rtl/puf_pkg.sv
package puf_pkg;
  localparam int WORD_W     = 32;
  localparam int MAG_W      = WORD_W - 1;
  localparam int POS_W      = 5;
  localparam int MAX_EXTRA  = 3;
  localparam int PLANES     = MAX_EXTRA + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS_A,
    ST_MEAS_B,
    ST_COMPARE,
    ST_NEXT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/ro_seq_ctrl.sv
module ro_seq_ctrl
  import puf_pkg::*;
#(
  parameter int N_PAIRS       = 100,
  parameter int SETTLE_CYCLES = 4,
  parameter int WIN_CYCLES    = 4096,
  parameter int PAIR_W        = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output seq_state_e        state_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              win_on_o,
  output logic              clr_o,
  output logic              cap_a_o,
  output logic              done_o
);
  localparam int TOTAL   = SETTLE_CYCLES + WIN_CYCLES;
  localparam int TIMER_W = $clog2(TOTAL + 1);

  seq_state_e        state_q, state_d;
  logic [TIMER_W-1:0] timer_q, timer_d;
  logic [PAIR_W-1:0]  pair_q, pair_d;
  logic               measuring;
  logic               last_tick;
  logic               last_pair;

  assign measuring = (state_q == ST_MEAS_A) || (state_q == ST_MEAS_B);
  assign last_tick = measuring && (timer_q == TIMER_W'(TOTAL - 1));
  assign last_pair = (pair_q == PAIR_W'(N_PAIRS - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_MEAS_A;
      ST_MEAS_A:  if (last_tick) state_d = ST_MEAS_B;
      ST_MEAS_B:  if (last_tick) state_d = ST_COMPARE;
      ST_COMPARE: state_d = ST_NEXT;
      ST_NEXT:    state_d = last_pair ? ST_DONE : ST_MEAS_A;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    timer_d = '0;
    if (measuring && !last_tick) timer_d = timer_q + 1'b1;
  end

  always_comb begin
    pair_d = pair_q;
    if (state_q == ST_IDLE && start_i)          pair_d = '0;
    else if (state_q == ST_NEXT && !last_pair)  pair_d = pair_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      pair_q  <= '0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      pair_q  <= pair_d;
    end
  end

  assign state_o  = state_q;
  assign pair_o   = pair_q;
  assign win_on_o = measuring && (timer_q >= TIMER_W'(SETTLE_CYCLES));
  assign clr_o    = measuring && (timer_q == '0);
  assign cap_a_o  = (state_q == ST_MEAS_A) && last_tick;
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/ro_edge_counter.sv
module ro_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog_i,
  input  logic             clr_i,
  input  logic             win_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign rise   = sync_q[1] & ~sync_q[2];
  assign at_max = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (win_i && rise && !at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ro_pair_word.sv
module ro_pair_word
  import puf_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0]  first_i,
  input  logic [CNT_W-1:0]  second_i,
  output logic [WORD_W-1:0] word_o
);
  logic             first_wins;
  logic [CNT_W-1:0] diff;

  assign first_wins = first_i > second_i;
  assign diff       = first_wins ? (first_i - second_i) : (second_i - first_i);
  assign word_o     = {first_wins, MAG_W'(diff)};
endmodule

// File: rtl/ro_resp_pack.sv
module ro_resp_pack
  import puf_pkg::*;
#(
  parameter int N_PAIRS = 100,
  parameter int PAIR_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        wr_i,
  input  logic [PAIR_W-1:0]           pair_i,
  input  logic [WORD_W-1:0]           word_i,
  input  logic [1:0]                  n_extra_i,
  input  logic [MAX_EXTRA*POS_W-1:0]  pos_i,
  output logic [PLANES*N_PAIRS-1:0]   resp_o
);
  logic [MAG_W-1:0] mag;
  assign mag = word_i[MAG_W-1:0];

  for (genvar j = 0; j < PLANES; j++) begin : g_plane
    logic [N_PAIRS-1:0] plane_q;
    logic               bit_val;

    if (j == 0) begin : g_sign
      assign bit_val = word_i[WORD_W-1];
    end else begin : g_mag
      logic [POS_W-1:0] pos;
      logic             in_range;
      assign pos      = pos_i[(j-1)*POS_W +: POS_W];
      assign in_range = (pos < POS_W'(MAG_W));
      assign bit_val  = (n_extra_i >= 2'(j)) && in_range && mag[pos];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       plane_q         <= '0;
      else if (clear_i) plane_q         <= '0;
      else if (wr_i)    plane_q[pair_i] <= bit_val;
    end

    assign resp_o[j*N_PAIRS +: N_PAIRS] = plane_q;
  end
endmodule

// File: rtl/ro_multibit_puf.sv
module ro_multibit_puf
  import puf_pkg::*;
#(
  parameter int N_OSC         = 200,
  parameter int CNT_W         = 20,
  parameter int WIN_CYCLES    = 4096,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           cfg_n_extra,
  input  logic [14:0]          cfg_pos,
  output logic [N_OSC-1:0]     osc_en,
  input  logic                 osc_toggle,
  output logic                 done,
  output logic [2*N_OSC-1:0]   response
);
  localparam int N_PAIRS = N_OSC / 2;
  localparam int PAIR_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1;
  localparam int OSC_W   = PAIR_W + 1;
  localparam int CFG_W   = MAX_EXTRA * POS_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  seq_state_e        state;
  logic [PAIR_W-1:0] pair;
  logic              win_on, clr, cap_a, accept;
  logic [CNT_W-1:0]  edge_cnt, held_a;
  logic [WORD_W-1:0] cmp_word;
  logic [1:0]        n_extra_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [OSC_W-1:0]  sel_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ro_seq_ctrl #(
    .N_PAIRS(N_PAIRS), .SETTLE_CYCLES(SETTLE_CYCLES),
    .WIN_CYCLES(WIN_CYCLES), .PAIR_W(PAIR_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(start), .state_o(state),
    .pair_o(pair), .win_on_o(win_on), .clr_o(clr), .cap_a_o(cap_a),
    .done_o(done)
  );

  assign accept = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      n_extra_q <= '0;
      cfg_q     <= '0;
    end else if (accept) begin
      n_extra_q <= cfg_n_extra;
      cfg_q     <= cfg_pos;
    end
  end

  ro_edge_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_int_n), .tog_i(osc_toggle), .clr_i(clr),
    .win_i(win_on), .cnt_o(edge_cnt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  held_a <= '0;
    else if (cap_a)  held_a <= edge_cnt;
  end

  ro_pair_word #(.CNT_W(CNT_W)) word_i (
    .first_i(held_a), .second_i(edge_cnt), .word_o(cmp_word)
  );

  ro_resp_pack #(.N_PAIRS(N_PAIRS), .PAIR_W(PAIR_W)) pack_i (
    .clk(clk), .rst_n(rst_int_n), .clear_i(accept),
    .wr_i(state == ST_COMPARE), .pair_i(pair), .word_i(cmp_word),
    .n_extra_i(n_extra_q), .pos_i(cfg_q), .resp_o(response)
  );

  assign sel_idx = {pair, (state == ST_MEAS_B)};

  for (genvar i = 0; i < N_OSC; i++) begin : g_en
    assign osc_en[i] = win_on && (sel_idx == OSC_W'(i));
  end
endmodule

// File: rtl/puf_chk.sv
module puf_chk
  import puf_pkg::*;
#(
  parameter int N_OSC = 200,
  parameter int CNT_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input seq_state_e          state,
  input logic [N_OSC-1:0]    osc_en,
  input logic                done,
  input logic [2*N_OSC-1:0]  response,
  input logic                win_on,
  input logic [CNT_W-1:0]    edge_cnt,
  input logic [CNT_W-1:0]    held_a,
  input logic [WORD_W-1:0]   cmp_word,
  input logic [14:0]         cfg_q
);
  p_onehot_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_en));

  p_gap_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPARE || state == ST_NEXT || state == ST_IDLE) |-> (osc_en == '0));

  p_count_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_on |=> (!win_on || edge_cnt >= $past(edge_cnt)));

  p_equal_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPARE && held_a == edge_cnt) |-> (cmp_word == '0));

  p_sign_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPARE && held_a > edge_cnt) |-> cmp_word[WORD_W-1]);

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cfg_q));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> $stable(response));
endmodule

bind ro_multibit_puf puf_chk #(.N_OSC(N_OSC), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .start(start), .state(state),
  .osc_en(osc_en), .done(done), .response(response), .win_on(win_on),
  .edge_cnt(edge_cnt), .held_a(held_a), .cmp_word(cmp_word), .cfg_q(cfg_q)
);

// File: tb/ro_multibit_puf_tb_top.sv
module ro_multibit_puf_tb_top;
  localparam int N_OSC  = 8;
  localparam int CNT_W  = 6;
  localparam int WIN    = 160;
  localparam int SETTLE = 4;
  localparam int NP     = N_OSC / 2;
  localparam int T      = SETTLE + WIN;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [1:0]         cfg_n_extra;
  logic [14:0]        cfg_pos;
  logic [N_OSC-1:0]   osc_en;
  logic               osc_toggle;
  logic               done;
  logic [2*N_OSC-1:0] response;

  int n_checks = 0;
  int n_fail   = 0;
  int cnt_tab [N_OSC];

  always #2 clk = ~clk;

  ro_multibit_puf #(
    .N_OSC(N_OSC), .CNT_W(CNT_W), .WIN_CYCLES(WIN), .SETTLE_CYCLES(SETTLE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_n_extra(cfg_n_extra),
    .cfg_pos(cfg_pos), .osc_en(osc_en), .osc_toggle(osc_toggle),
    .done(done), .response(response)
  );

  task automatic check(input bit ok, input string req, input logic [2*N_OSC-1:0] act,
                       input logic [2*N_OSC-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Oscillator array model: emits the tabled number of edges for the enabled index.
  initial begin
    osc_toggle = 1'b0;
    forever begin
      @(negedge clk);
      if (|osc_en) begin
        int idx = 0;
        for (int i = 0; i < N_OSC; i++) if (osc_en[i]) idx = i;
        repeat (3) @(negedge clk);
        for (int p = 0; p < cnt_tab[idx]; p++) begin
          osc_toggle = 1'b1;
          @(negedge clk);
          osc_toggle = 1'b0;
          @(negedge clk);
        end
        while (|osc_en) @(negedge clk);
      end
    end
  end

  function automatic logic [2*N_OSC-1:0] expect_resp(input int n_extra, input int p0,
                                                     input int p1, input int p2);
    logic [2*N_OSC-1:0] r = '0;
    int pos [3];
    pos[0] = p0; pos[1] = p1; pos[2] = p2;
    for (int k = 0; k < NP; k++) begin
      int a = (cnt_tab[2*k]   > CMAX) ? CMAX : cnt_tab[2*k];
      int b = (cnt_tab[2*k+1] > CMAX) ? CMAX : cnt_tab[2*k+1];
      int m = (a > b) ? a - b : b - a;
      r[k] = (a > b);
      for (int j = 0; j < 3; j++)
        if (j < n_extra && pos[j] <= 30) r[(j+1)*NP + k] = (m >> pos[j]) & 1;
    end
    return r;
  endfunction

  task automatic run(input int n_extra, input int p0, input int p1, input int p2,
                     input bit mid_change, input string tag);
    logic [2*N_OSC-1:0] exp_r = expect_resp(n_extra, p0, p1, p2);
    int en_bad = 0;
    @(negedge clk);
    cfg_n_extra = 2'(n_extra);
    cfg_pos     = {5'(p2), 5'(p1), 5'(p0)};
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NP; k++) begin
      if (mid_change && k == 1) begin
        cfg_n_extra = 2'd3;
        cfg_pos     = {5'd2, 5'd1, 5'd0};
      end
      for (int ph = 0; ph < 2; ph++)
        for (int t = 0; t < T; t++) begin
          logic [N_OSC-1:0] e = (t >= SETTLE) ? N_OSC'(1) << (2*k + ph) : '0;
          if (osc_en !== e || done !== 1'b0) begin
            en_bad++;
            check(1'b0, "R1 enable schedule", 2*N_OSC'(osc_en), 2*N_OSC'(e));
          end
          @(negedge clk);
        end
      for (int g = 0; g < 2; g++) begin
        if (osc_en !== '0 || done !== 1'b0) begin
          en_bad++;
          check(1'b0, "R1 gap between pairs", 2*N_OSC'(osc_en), '0);
        end
        @(negedge clk);
      end
    end
    check(en_bad == 0, "R1 schedule clean", 2*N_OSC'(en_bad), '0);
    check(done === 1'b1, "R7 done asserted", 2*N_OSC'(done), 1);
    check(response === exp_r, tag, response, exp_r);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", 2*N_OSC'(done), 0);
    repeat (10) @(negedge clk);
    check(response === exp_r, "R7 response held", response, exp_r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_n_extra = '0; cfg_pos = '0;
    for (int i = 0; i < N_OSC; i++) cnt_tab[i] = 0;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && osc_en === '0, "R8 outputs in reset", 2*N_OSC'(osc_en), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(response === '0, "R8 response after reset", response, '0);
    check(osc_en === '0 && done === 1'b0, "R8 idle after reset", 2*N_OSC'(osc_en), '0);

    // R3 sign plane only, including one equal pair
    cnt_tab = '{10, 20, 30, 5, 40, 40, 7, 8};
    run(0, 0, 0, 0, 1'b0, "R3 R5 sign-only response");

    // R4 three low planes, equal pair gives zero magnitude
    cnt_tab = '{13, 6, 20, 27, 50, 50, 1, 63};
    run(3, 0, 1, 2, 1'b0, "R4 R5 three magnitude planes");

    // R2 saturation above 63, two planes at unordered positions, one unused
    cnt_tab = '{70, 40, 64, 0, 2, 60, 63, 70};
    run(2, 5, 3, 31, 1'b0, "R2 R5 saturated counts");

    // R6 configuration changed during the run is ignored
    cnt_tab = '{33, 1, 0, 16, 17, 49, 25, 25};
    run(1, 4, 9, 9, 1'b1, "R6 mid-run configuration ignored");

    // R4 position above 30 reads as zero
    cnt_tab = '{60, 1, 2, 61, 33, 0, 9, 40};
    run(3, 31, 0, 5, 1'b0, "R4 out-of-range position");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule